// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal sync, vertical sync, a data-enable window and a pixel strobe. It also outputs the current column and row inside the visible area, so an upstream pixel source knows which pixel to present. The pixel rate comes from a programmable divider on the system clock, or from the system clock itself when the divider is bypassed. The configuration inputs describe each part of the line and the frame. Each field uses its own fixed offset encoding. The block copies these fields into shadow registers when it starts and again at each frame boundary, so a change made during a frame first applies to the next frame.

Each line is made of four segments in this order: sync pulse, back porch, active pixels and front porch. The frame is made of the same four segments, counted in lines. The polarity of each sync output can be set live. A display-on output stays low for a programmable number of whole frames after timing starts, plus one more frame when an extra delay bit is set. A second delay bit moves the vertical sync pulse one pixel later. A colour-packing code (12, 16, 18 or 24 bits per pixel) is passed out at each frame start for the downstream data path.

The panel cannot stall, so the position outputs carry no back-pressure. The upstream source must have the pixel ready on every strobe while data enable is high. A zero-width divisor does not exist: the smallest divided rate is one pixel every two clocks.

Top module: `lcd_timing_gen`

## Requirements
- R1: With `cfg_sysclk`=0, `pix_stb` pulses once every `cfg_div`+2 clocks while running. With `cfg_sysclk`=1, it is high on every clock while running. The first pulse comes `cfg_div`+2 clocks (or 1 clock in bypass) after the first running cycle.
- R2: A line lasts `cfg_hsw`+1 + `cfg_hbp`+1 + `cfg_hact`+1 + `cfg_hfp`+1 pixel strobes, in the order sync, back porch, active, front porch. The horizontal sync pulse is active during the first `cfg_hsw`+1 strobes.
- R3: A frame lasts `cfg_vsw`+1 + `cfg_vbp` + `cfg_vact`+1 + `cfg_vfp`+1 lines, in the order sync, back porch, active, front porch. The vertical back porch has no offset and may be zero lines.
- R4: `de` is high only when the line and the frame are both in their active segments. `act_x` and `act_y` give the offset from the start of the horizontal and vertical active segments, and are 0 outside them.
- R5: `cfg_hs_low`=1 or `cfg_vs_low`=1 inverts the level of `hsync` or `vsync`, including the idle level. The change takes effect on the next cycle without waiting for a frame boundary.
- R6: All timing, divider, mode, guard and delay fields are captured on the first running cycle and at each frame wrap. A change made at any other time has no effect on the outputs until the next frame.
- R7: `pix_mode` encodes 0 = 12 bpp, 1 = 16 bpp, 2 = 18 bpp, 3 = 24 bpp. It is 3 after reset and follows `cfg_mode` only at frame capture.
- R8: `disp_on` stays low until `cfg_guard` + `cfg_disp_dly` whole frames have finished since timing started. With both set to 0 it rises together with the start of timing.
- R9: With `cfg_vs_dly`=1, `vsync` follows the vertical sync segment one pixel strobe later.
- R10: While `en` is low, the block is idle from the next cycle: no strobe, `de`=0, both syncs at their inactive level, `disp_on`=0 and positions 0. Raising `en` again restarts timing from the frame start.
- R11: After reset, all outputs are idle and `pix_mode` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run timing when high |
| cfg_hsw | input | HW | Horizontal sync width minus one |
| cfg_hbp | input | HW | Horizontal back porch minus one |
| cfg_hact | input | HW | Pixels per line minus one |
| cfg_hfp | input | HW | Horizontal front porch minus one |
| cfg_vsw | input | VW | Vertical sync width minus one (lines) |
| cfg_vbp | input | VW | Vertical back porch in lines, no offset |
| cfg_vact | input | VW | Rows per frame minus one |
| cfg_vfp | input | VW | Vertical front porch minus one |
| cfg_div | input | DW | Pixel divisor minus two |
| cfg_sysclk | input | 1 | Use the system clock as the pixel rate |
| cfg_mode | input | 2 | Colour packing code (see R7) |
| cfg_guard | input | GW | Frames to wait before display-on |
| cfg_disp_dly | input | 1 | Add one more guard frame |
| cfg_vs_dly | input | 1 | Move vsync one pixel later |
| cfg_hs_low | input | 1 | Horizontal sync active low |
| cfg_vs_low | input | 1 | Vertical sync active low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_stb | output | 1 | One-clock pixel strobe |
| act_x | output | HW | Active column |
| act_y | output | VW | Active row |
| disp_on | output | 1 | Display enable after guard frames |
| pix_mode | output | 2 | Captured colour packing code |

## Verification
Every output is decoded without extra registers from state that updates on the clock edge. A change of `en` or of a captured field therefore shows after the next edge, and a polarity change shows at once on the following cycle. Segment and strobe outputs change only on the edge that carries a strobe, which comes `cfg_div`+2 clocks apart. `pix_mode` moves only at frame capture, and `disp_on` moves one edge after the strobe that ends the last guard frame. The bench steps a behavioural integer model at each rising edge, using the same inputs the design sees, and compares all outputs at the falling edge of every cycle. In this way each result is checked in exactly the cycle it falls due.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  typedef enum logic [1:0] {
    PM_12 = 2'd0,
    PM_16 = 2'd1,
    PM_18 = 2'd2,
    PM_24 = 2'd3
  } pix_mode_e;
endpackage

// File: rtl/lcd_tg_div.sv
module lcd_tg_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          bypass,
  input  logic [DW-1:0] div_m2,
  output logic          stb
);
  localparam int CW = DW + 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  assign term = {1'b0, div_m2} + CW'(1);
  assign stb  = run && (bypass || cnt == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (stb)    cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bypass && $past(stb)) |-> !stb); // R1
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int W        = 11,
  parameter bit BP_PLUS1 = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] f_sync,
  input  logic [W-1:0] f_bp,
  input  logic [W-1:0] f_act,
  input  logic [W-1:0] f_fp,
  output logic         seg_sync,
  output logic         seg_act,
  output logic         last,
  output logic         wrap,
  output logic [W-1:0] act_idx
);
  localparam int CW = W + 2;
  logic [CW-1:0] pos, l_sync, l_bp, l_act, l_fp;
  logic [CW-1:0] b_act, e_act, tot_m1, diff;

  assign l_sync = {2'b00, f_sync} + CW'(1);
  assign l_act  = {2'b00, f_act}  + CW'(1);
  assign l_fp   = {2'b00, f_fp}   + CW'(1);

  generate
    if (BP_PLUS1) begin : g_bp_m1
      assign l_bp = {2'b00, f_bp} + CW'(1);
    end else begin : g_bp_raw
      assign l_bp = {2'b00, f_bp};
    end
  endgenerate

  assign b_act  = l_sync + l_bp;
  assign e_act  = b_act + l_act;
  assign tot_m1 = e_act + l_fp - CW'(1);

  assign last     = (pos == tot_m1);
  assign wrap     = step && last;
  assign seg_sync = (pos < l_sync);
  assign seg_act  = (pos >= b_act) && (pos < e_act);
  assign diff     = pos - b_act;
  assign act_idx  = seg_act ? diff[W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (clr)   pos <= '0;
    else if (step)  pos <= last ? '0 : pos + CW'(1);
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> pos <= tot_m1); // R2
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step && !last) |=> pos == $past(pos) + CW'(1)); // R2
  AST_IDX_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    seg_act |-> diff[CW-1:W] == '0); // R4
endmodule

// File: rtl/lcd_tg_guard.sv
module lcd_tg_guard #(
  parameter int GW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        frame_done,
  input  logic [GW:0] need,
  output logic        disp_on
);
  logic [GW:0] fcnt;

  assign disp_on = run && (fcnt >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         fcnt <= '0;
    else if (!run)                      fcnt <= '0;
    else if (frame_done && fcnt != '1)  fcnt <= fcnt + (GW+1)'(1);
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int DW = 8,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] cfg_hsw,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [VW-1:0] cfg_vsw,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [DW-1:0] cfg_div,
  input  logic          cfg_sysclk,
  input  logic [1:0]    cfg_mode,
  input  logic [GW-1:0] cfg_guard,
  input  logic          cfg_disp_dly,
  input  logic          cfg_vs_dly,
  input  logic          cfg_hs_low,
  input  logic          cfg_vs_low,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_stb,
  output logic [HW-1:0] act_x,
  output logic [VW-1:0] act_y,
  output logic          disp_on,
  output logic [1:0]    pix_mode
);
  import lcd_tg_pkg::*;

  logic          running, load, frame_wrap, vs_d, vs_raw;
  logic [HW-1:0] sh_hsw, sh_hbp, sh_hact, sh_hfp, hidx;
  logic [VW-1:0] sh_vsw, sh_vbp, sh_vact, sh_vfp, vidx;
  logic [DW-1:0] sh_div;
  logic [GW-1:0] sh_guard;
  logic          sh_sysclk, sh_disp_dly, sh_vs_dly;
  pix_mode_e     sh_mode;
  logic          h_sync, h_act, h_last, h_wrap;
  logic          v_sync, v_act, v_last;
  logic [GW:0]   need;

  assign load = en && (!running || frame_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hsw <= '0; sh_hbp <= '0; sh_hact <= '0; sh_hfp <= '0;
      sh_vsw <= '0; sh_vbp <= '0; sh_vact <= '0; sh_vfp <= '0;
      sh_div <= '0; sh_sysclk <= 1'b0; sh_mode <= PM_24;
      sh_guard <= '0; sh_disp_dly <= 1'b0; sh_vs_dly <= 1'b0;
    end else if (load) begin
      sh_hsw <= cfg_hsw; sh_hbp <= cfg_hbp; sh_hact <= cfg_hact; sh_hfp <= cfg_hfp;
      sh_vsw <= cfg_vsw; sh_vbp <= cfg_vbp; sh_vact <= cfg_vact; sh_vfp <= cfg_vfp;
      sh_div <= cfg_div; sh_sysclk <= cfg_sysclk; sh_mode <= pix_mode_e'(cfg_mode);
      sh_guard <= cfg_guard; sh_disp_dly <= cfg_disp_dly; sh_vs_dly <= cfg_vs_dly;
    end
  end

  lcd_tg_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(running), .bypass(sh_sysclk),
    .div_m2(sh_div), .stb(pix_stb)
  );

  lcd_tg_axis #(.W(HW), .BP_PLUS1(1'b1)) u_hax (
    .clk(clk), .rst_n(rst_n), .clr(!running), .step(pix_stb),
    .f_sync(sh_hsw), .f_bp(sh_hbp), .f_act(sh_hact), .f_fp(sh_hfp),
    .seg_sync(h_sync), .seg_act(h_act), .last(h_last), .wrap(h_wrap),
    .act_idx(hidx)
  );

  lcd_tg_axis #(.W(VW), .BP_PLUS1(1'b0)) u_vax (
    .clk(clk), .rst_n(rst_n), .clr(!running), .step(h_wrap),
    .f_sync(sh_vsw), .f_bp(sh_vbp), .f_act(sh_vact), .f_fp(sh_vfp),
    .seg_sync(v_sync), .seg_act(v_act), .last(v_last), .wrap(frame_wrap),
    .act_idx(vidx)
  );

  assign need = {1'b0, sh_guard} + (GW+1)'(sh_disp_dly);

  lcd_tg_guard #(.GW(GW)) u_guard (
    .clk(clk), .rst_n(rst_n), .run(running), .frame_done(frame_wrap),
    .need(need), .disp_on(disp_on)
  );

  assign vs_raw = running && v_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vs_d <= 1'b0;
    else if (!running) vs_d <= 1'b0;
    else if (pix_stb)  vs_d <= vs_raw;
  end

  assign hsync    = (running && h_sync) ^ cfg_hs_low;
  assign vsync    = (sh_vs_dly ? vs_d : vs_raw) ^ cfg_vs_low;
  assign de       = running && h_act && v_act;
  assign act_x    = (running && h_act) ? hidx : '0;
  assign act_y    = (running && v_act) ? vidx : '0;
  assign pix_mode = sh_mode;

  AST_DE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (act_x <= sh_hact) && (act_y <= sh_vact)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(load)) |->
      ($stable(sh_hact) && $stable(sh_vact) && $stable(sh_div))); // R6
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(pix_mode)); // R7
  AST_DISP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_on) |-> ($past(frame_wrap) || $rose(running))); // R8
  AST_LAST_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap) |-> (h_last && v_last)); // R3
endmodule

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/100ps
module lcd_timing_gen_test;
  localparam int HW = 11, VW = 11, DW = 8, GW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0;
  logic [HW-1:0] cfg_hsw = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hfp = '0;
  logic [VW-1:0] cfg_vsw = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
  logic [DW-1:0] cfg_div = '0;
  logic cfg_sysclk = 0, cfg_disp_dly = 0, cfg_vs_dly = 0, cfg_hs_low = 0, cfg_vs_low = 0;
  logic [1:0] cfg_mode = 2'd3;
  logic [GW-1:0] cfg_guard = '0;

  logic hsync, vsync, de, pix_stb, disp_on;
  logic [HW-1:0] act_x;
  logic [VW-1:0] act_y;
  logic [1:0] pix_mode;

  lcd_timing_gen #(.HW(HW), .VW(VW), .DW(DW), .GW(GW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .cfg_div(cfg_div), .cfg_sysclk(cfg_sysclk), .cfg_mode(cfg_mode),
    .cfg_guard(cfg_guard), .cfg_disp_dly(cfg_disp_dly), .cfg_vs_dly(cfg_vs_dly),
    .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_stb(pix_stb),
    .act_x(act_x), .act_y(act_y), .disp_on(disp_on), .pix_mode(pix_mode)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "R11 reset";

  // behavioural model state
  int m_run, m_dc, m_h, m_v, m_vsd, m_fc, m_mode;
  int s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf, s_div, s_byp, s_g, s_dd, s_vsdly;

  function automatic int htot();
    return s_hs + s_hb + s_ha + s_hf + 4;
  endfunction
  function automatic int vtot();
    return s_vs + s_vb + s_va + s_vf + 3;
  endfunction
  function automatic int m_stb();
    return (m_run != 0 && (s_byp != 0 || m_dc == s_div + 1)) ? 1 : 0;
  endfunction
  function automatic int m_vsraw();
    return (m_run != 0 && m_v < s_vs + 1) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_dc = 0; m_h = 0; m_v = 0; m_vsd = 0; m_fc = 0; m_mode = 3;
      s_hs = 0; s_hb = 0; s_ha = 0; s_hf = 0; s_vs = 0; s_vb = 0; s_va = 0; s_vf = 0;
      s_div = 0; s_byp = 0; s_g = 0; s_dd = 0; s_vsdly = 0;
    end else begin
      int stb, wrapf, vsr, ld;
      stb = m_stb();
      vsr = m_vsraw();
      wrapf = (stb != 0 && m_h == htot() - 1 && m_v == vtot() - 1) ? 1 : 0;
      ld = (en && (m_run == 0 || wrapf != 0)) ? 1 : 0;
      if (m_run == 0) begin
        m_dc = 0; m_h = 0; m_v = 0; m_vsd = 0; m_fc = 0;
      end else begin
        if (stb != 0) begin
          m_dc = 0;
          m_vsd = vsr;
          if (m_h == htot() - 1) begin
            m_h = 0;
            m_v = (m_v == vtot() - 1) ? 0 : m_v + 1;
          end else m_h = m_h + 1;
        end else m_dc = m_dc + 1;
        if (wrapf != 0 && m_fc < 31) m_fc = m_fc + 1;
      end
      if (ld != 0) begin
        s_hs = cfg_hsw; s_hb = cfg_hbp; s_ha = cfg_hact; s_hf = cfg_hfp;
        s_vs = cfg_vsw; s_vb = cfg_vbp; s_va = cfg_vact; s_vf = cfg_vfp;
        s_div = cfg_div; s_byp = cfg_sysclk; m_mode = cfg_mode;
        s_g = cfg_guard; s_dd = cfg_disp_dly; s_vsdly = cfg_vs_dly;
      end
      m_run = en ? 1 : 0;
    end
  end

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", phase, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int hab, vab, ha, va, ex, ey, vs_lvl;
      hab = s_hs + s_hb + 2;
      vab = s_vs + s_vb + 1;
      ha = (m_run != 0 && m_h >= hab && m_h < hab + s_ha + 1) ? 1 : 0;
      va = (m_run != 0 && m_v >= vab && m_v < vab + s_va + 1) ? 1 : 0;
      ex = (ha != 0) ? m_h - hab : 0;
      ey = (va != 0) ? m_v - vab : 0;
      vs_lvl = (s_vsdly != 0) ? m_vsd : m_vsraw();
      chk("R1 pix_stb", pix_stb, m_stb());
      chk("R2 R5 hsync", hsync, ((m_run != 0 && m_h < s_hs + 1) ? 1 : 0) ^ cfg_hs_low);
      chk("R3 R5 R9 vsync", vsync, vs_lvl ^ cfg_vs_low);
      chk("R4 de", de, ha & va);
      chk("R4 act_x", act_x, ex);
      chk("R4 act_y", act_y, ey);
      chk("R8 disp_on", disp_on, (m_run != 0 && m_fc >= s_g + s_dd) ? 1 : 0);
      chk("R7 pix_mode", pix_mode, m_mode);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    phase = "R11 reset idle"; tick(10);
    // basic raster
    cfg_hsw = 1; cfg_hbp = 0; cfg_hact = 3; cfg_hfp = 1;
    cfg_vsw = 0; cfg_vbp = 1; cfg_vact = 2; cfg_vfp = 0;
    cfg_div = 0; cfg_guard = 1; cfg_mode = 2'd0;
    phase = "R1 R2 R3 R4 basic"; en = 1; tick(400);
    phase = "R6 R3 midframe"; tick(30);
    cfg_hact = 5; cfg_vbp = 0; cfg_div = 1; cfg_hbp = 2; tick(600);
    phase = "R5 polarity"; cfg_hs_low = 1; cfg_vs_low = 1; tick(300);
    cfg_hs_low = 0; tick(50);
    phase = "R7 mode"; cfg_mode = 2'd1; tick(200); cfg_mode = 2'd2; tick(300);
    phase = "R9 vsdelay"; cfg_vs_dly = 1; tick(600);
    phase = "R10 disable"; en = 0; tick(20);
    en = 1; tick(200);
    phase = "R8 guard"; en = 0; cfg_guard = 3; cfg_disp_dly = 1; tick(5);
    en = 1; tick(1000);
    phase = "R8 guard zero"; en = 0; cfg_guard = 0; cfg_disp_dly = 0; tick(5);
    en = 1; tick(100);
    phase = "R1 bypass"; cfg_sysclk = 1; cfg_div = 5; tick(400);
    phase = "R10 idle end"; en = 0; tick(20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule